// File: doc/BRIEF.md
# Pixel Depth Expander

This block takes per-channel pixel components that arrive on a 12-bit bus with the significant bits at the top. A source of 8 or 10 bits per channel leaves its low 4 or 2 bits at zero. When the output link is a digital display link, the block fills those low bits from the component's own most significant bits. A full-scale narrow code therefore becomes full-scale 12-bit (0xFF becomes 0xFFF) rather than stopping at 0xFF0.

The block chooses its enable and its mode code from a link-type input and a colour-depth input. Mode 0 widens 10 bits to 12 and mode 1 widens 8 bits to 12. All three components of a pixel are processed in parallel. Output data and valid are registered, with a latency of one cycle.

Top module: `pix_depth_expand`

## Requirements
- R1: Link codes are 0 = HDMI, 1 = DisplayPort, 2 = DisplayPort multi-stream and 3 = other. Expansion is enabled only for codes 0, 1 and 2. For code 3 the data passes through unchanged.
- R2: Depth codes are 0 = 8 bits, 1 = 10 bits, 2 = 12 bits and 3 = unsupported. On an enabled link, depth 0 selects mode 1 (8 to 12) and depth 1 selects mode 0 (10 to 12).
- R3: In mode 1, output bits 11:4 equal input bits 11:4, and output bits 3:0 equal input bits 11:8.
- R4: In mode 0, output bits 11:2 equal input bits 11:2, and output bits 1:0 equal input bits 11:10.
- R5: For a 12-bit source on an enabled link, the block stays enabled in mode 0. The two low bits are then replaced by the top two bits and are never forced to zero.
- R6: Depth code 3 disables expansion, and the data passes through unchanged.
- R7: Output data and output valid follow the input by exactly one clock cycle. The output holds its value while the input valid is low.
- R8: A synchronous active-high reset clears the output valid and the output data to zero.
- R9: The three components of a pixel are expanded independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_sel | input | 2 | Link type code |
| depth_sel | input | 2 | Source colour depth code |
| in_valid | input | 1 | Input pixel valid |
| in_pix | input | 36 | Three 12-bit components, component 0 in bits 11:0 |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 36 | Three expanded 12-bit components |

## Verification
The bench sweeps every 8-bit code in mode 1 and every 10-bit code in mode 0 across all four link types. The extremes matter most: 0x00 must stay 0x000, and 0xFF must reach 0xFFF.

- A design that swapped the two mode codes would copy the wrong number of bits.
- A design that disabled expansion for 12-bit sources would leave the low bits as they arrived, which random 12-bit values expose.
- A design that enabled expansion on the "other" link, or for the unsupported depth, would change data that must pass through untouched.
- The components carry different values at the same time, so any cross-wiring between components shows up.

// File: rtl/pde_pkg.sv
package pde_pkg;
    localparam int COMP_W = 12;
    localparam int N_COMP = 3;
    localparam int PIX_W  = COMP_W * N_COMP;

    typedef enum logic [1:0] {
        LINK_HDMI = 2'd0,
        LINK_DP   = 2'd1,
        LINK_DPMS = 2'd2,
        LINK_OTH  = 2'd3
    } link_e;

    typedef enum logic [1:0] {
        DEP_8  = 2'd0,
        DEP_10 = 2'd1,
        DEP_12 = 2'd2,
        DEP_XX = 2'd3
    } depth_e;

    typedef struct packed {
        logic en;
        logic mode;  // 0: 10->12, 1: 8->12
    } xcfg_t;

    function automatic xcfg_t derive_cfg(link_e l, depth_e d);
        xcfg_t c;
        c.en   = 1'b0;
        c.mode = 1'b0;
        if (l != LINK_OTH) begin
            case (d)
                DEP_8:   begin c.en = 1'b1; c.mode = 1'b1; end
                DEP_10:  begin c.en = 1'b1; c.mode = 1'b0; end
                DEP_12:  begin c.en = 1'b1; c.mode = 1'b0; end
                default: begin c.en = 1'b0; c.mode = 1'b0; end
            endcase
        end
        return c;
    endfunction
endpackage

// File: rtl/pde_cfg.sv
module pde_cfg
    import pde_pkg::*;
(
    input  logic [1:0] link_sel,
    input  logic [1:0] depth_sel,
    output xcfg_t      cfg
);
    always_comb cfg = derive_cfg(link_e'(link_sel), depth_e'(depth_sel));
endmodule

// File: rtl/pde_lane.sv
module pde_lane
    import pde_pkg::*;
#(
    parameter int W = COMP_W
) (
    input  xcfg_t        cfg,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int FILL8  = 4;
    localparam int FILL10 = 2;

    always_comb begin
        dout = din;
        if (cfg.en) begin
            if (cfg.mode)
                dout[FILL8-1:0] = din[W-1 -: FILL8];
            else
                dout[FILL10-1:0] = din[W-1 -: FILL10];
        end
    end
endmodule

// File: rtl/pix_depth_expand.sv
module pix_depth_expand
    import pde_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       link_sel,
    input  logic [1:0]       depth_sel,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);
    xcfg_t            cfg;
    logic [PIX_W-1:0] exp_pix;

    pde_cfg u_cfg (
        .link_sel  (link_sel),
        .depth_sel (depth_sel),
        .cfg       (cfg)
    );

    for (genvar i = 0; i < N_COMP; i++) begin : g_lane
        pde_lane #(.W(COMP_W)) u_lane (
            .cfg  (cfg),
            .din  (in_pix[i*COMP_W +: COMP_W]),
            .dout (exp_pix[i*COMP_W +: COMP_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_pix <= exp_pix;
        end
    end
endmodule

// File: rtl/pix_depth_expand_chk.sv
module pix_depth_expand_chk
    import pde_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [1:0]       link_sel,
    input logic [1:0]       depth_sel,
    input logic             in_valid,
    input logic [PIX_W-1:0] in_pix,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_pix
);
    AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> out_valid == $past(in_valid)); // R7

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(in_valid)) |-> $stable(out_pix)); // R7

    AST_PASS_OTHER: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(in_valid) && $past(link_sel) == 2'd3)
        |-> out_pix == $past(in_pix)); // R1

    AST_PASS_BADDEPTH: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(in_valid) && $past(depth_sel) == 2'd3)
        |-> out_pix == $past(in_pix)); // R6

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(in_valid))
        |-> out_pix[11:4] == $past(in_pix[11:4])); // R3

    AST_RESET_CLR: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_pix == '0)); // R8
endmodule

bind pix_depth_expand pix_depth_expand_chk u_chk (.*);

// File: tb/pix_depth_expand_test.sv
module pix_depth_expand_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  link_sel = '0;
    logic [1:0]  depth_sel = '0;
    logic        in_valid = 1'b0;
    logic [35:0] in_pix = '0;
    logic        out_valid;
    logic [35:0] out_pix;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pix_depth_expand uut (.*);

    function automatic logic [11:0] model(logic [1:0] l, logic [1:0] d, logic [11:0] x);
        logic [11:0] r = x;
        if (l != 2'd3) begin
            if (d == 2'd0) r[3:0] = x[11:8];
            else if (d == 2'd1 || d == 2'd2) r[1:0] = x[11:10];
        end
        return r;
    endfunction

    task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [1:0] l, logic [1:0] d, logic [35:0] p, string req);
        logic [35:0] e;
        @(negedge clk);
        link_sel = l; depth_sel = d; in_pix = p; in_valid = 1'b1;
        for (int k = 0; k < 3; k++) e[k*12 +: 12] = model(l, d, p[k*12 +: 12]);
        @(negedge clk);
        chk(req, out_pix, e);
        chk("R7", {35'd0, out_valid}, 36'd1);
        in_valid = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [35:0] held;
        repeat (3) @(negedge clk);
        chk("R8", {out_pix[34:0], out_valid}, 36'd0);
        rst = 1'b0;
        // R3 R2: full sweep of 8-bit codes on each link
        for (int l = 0; l < 4; l++)
            for (int v = 0; v < 256; v++)
                apply(2'(l), 2'd0,
                      {8'(v ^ 8'h5A), 4'h0, 8'(255 - v), 4'h0, 8'(v), 4'h0},
                      l == 3 ? "R1" : "R3");
        // R4: full sweep of 10-bit codes
        for (int v = 0; v < 1024; v++)
            apply(2'd1, 2'd1, {10'(v ^ 10'h2A5), 2'b0, 10'(1023 - v), 2'b0, 10'(v), 2'b0}, "R4");
        // R5 R6 R9: 12-bit and unsupported depth with arbitrary values
        for (int v = 0; v < 512; v++) begin
            apply(2'(v % 3), 2'd2, {12'(v * 37), 12'(v * 11 + 5), 12'(v ^ 12'hC3F)}, "R5");
            apply(2'(v % 3), 2'd3, {12'(v * 29), 12'(v + 1), 12'(v ^ 12'h9E1)}, "R6");
        end
        // R9: distinct corner values per component
        apply(2'd2, 2'd0, {12'hFF0, 12'h000, 12'h800}, "R9");
        // R7: hold while valid low
        held = out_pix;
        @(negedge clk);
        in_pix = 36'hABCABCABC; link_sel = 2'd0; depth_sel = 2'd0;
        repeat (3) @(negedge clk);
        chk("R7", out_pix, held);
        chk("R7", {35'd0, out_valid}, 36'd0);
        // R8: reset mid-stream
        rst = 1'b1;
        @(negedge clk);
        chk("R8", {out_pix[34:0], out_valid}, 36'd0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule